// File: doc/BRIEF.md
# Debounced Key Scanner with Event Queue

The block walks a matrix of up to 64 keys one position at a time. It presents an encoded row number to an external decoder and samples one active-low return column per step. It accepts a closure only after the key has been seen on three consecutive visits, which is two full scans after it was first found. The accepted key code is packed with the state of the shift and control inputs and placed in an eight-entry queue. The queue is drained by a read strobe, and an interrupt output and a status byte report its state.

Two arbitration policies are available for keyboard use. In the first, two keys in debounce at the same time lock each other out. In the second, every key is handled on its own, with an optional strict variant that flags simultaneous presses. A third mode ignores the matrix: it captures the raw return-line byte on each falling edge of the strobe input. A clear input empties the queue and resets its flags.

Top module: `key_scan_ctrl`

## Requirements
- R1: In keyboard modes a key at (row, column) is closed when return line `ret_ni[column]` is low while `scan_row_o` equals row. Its entry holds bit7 = 1 when `ctrl_stb_ni` is low, bit6 = 1 when `shift_ni` is low, bits 5..3 = row and bits 2..0 = column.
- R2: A key is entered only after it is found closed on its first visit and on the two following visits (one full scan apart). A key released before that produces no entry.
- R3: With `mode_i` = 00 (two-key lockout), no key is entered while another key is also in debounce. Once only one of them remains closed, that key is entered.
- R4: In two-key lockout each depression is entered exactly once, however long it is held. A key pressed while an already accepted key is held is entered as well.
- R5: With `mode_i` = 01 (rollover), every debounced key is entered, in the order the scan reaches them: row ascending, then column ascending.
- R6: The queue holds 8 entries and returns them oldest first. A key validated while 8 entries are held is dropped, and status bit5 (overrun) is set.
- R7: `irq_o` is low while the queue is empty. It is low in the cycle after each read, and high in every other cycle in which entries remain.
- R8: With `err_mode_i` = 1 in rollover mode, a key that validates while another key is in debounce sets status bit6 and is not entered. While bit6 is set no entry is written, but reads and `irq_o` behave normally.
- R9: With `mode_i[1]` = 1 (strobed), each falling edge of `ctrl_stb_ni` enters the raw `ret_ni` byte once. Matrix keys are ignored in this mode.
- R10: A one-cycle pulse on `clr_i` empties the queue, clears status bits 6..3 and drives `irq_o` low.
- R11: Status bits 2..0 give the entry count modulo 8 and bit3 is set when 8 entries are held. Bit4 (underrun) is set by a read of an empty queue, which leaves the queue unchanged. Bit7 reads 0, and all bits are 0 after reset.
- R12: A read and a write in the same cycle both take effect, so the count is unchanged and the new entry lands behind the remaining ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 00 two-key lockout, 01 rollover, 1x strobed |
| err_mode_i | input | 1 | Simultaneous-press error enable (rollover only) |
| ret_ni | input | 8 | Return lines, low = closed |
| shift_ni | input | 1 | Shift key, low = pressed |
| ctrl_stb_ni | input | 1 | Control key in keyboard modes, strobe in strobed mode |
| scan_row_o | output | 3 | Encoded scan row |
| rd_i | input | 1 | Read strobe, pops the head entry |
| clr_i | input | 1 | Clear queue and flags |
| rd_data_o | output | 8 | Head entry of the queue |
| status_o | output | 8 | Count, full, underrun, overrun, simultaneous error |
| irq_o | output | 1 | Interrupt, entries pending |

## Verification
A read strobe and a queue write can fall in the same cycle. Strobed mode is used to provoke this, because a write there happens exactly at the first edge that sees the strobe low. The bench lowers the strobe and raises the read in the same half-cycle while two entries are queued. It then judges that the count stays at two and that the remaining entries come out in order, with the new byte last. Matrix sweeps over all 64 keys, together with the lockout, rollover and error scenarios, are timed against whole scans of 128 cycles.

// File: rtl/kscan_pkg.sv
package kscan_pkg;
  localparam logic [1:0] MODE_LOCKOUT  = 2'b00;
  localparam logic [1:0] MODE_ROLLOVER = 2'b01;

  typedef enum logic [1:0] {
    KS_OPEN = 2'd0,
    KS_SEEN = 2'd1,
    KS_HOLD = 2'd2,
    KS_DONE = 2'd3
  } kstate_e;
endpackage

// File: rtl/kscan_timer.sv
module kscan_timer #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int DIV  = 2,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS),
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             tick_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o
);
  logic [DIV_W-1:0] div_q;

  assign tick_o = (div_q == DIV_W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      row_o <= '0;
      col_o <= '0;
    end else if (tick_o) begin
      div_q <= '0;
      if (col_o == COL_W'(COLS - 1)) begin
        col_o <= '0;
        row_o <= (row_o == ROW_W'(ROWS - 1)) ? '0 : row_o + 1'b1;
      end else begin
        col_o <= col_o + 1'b1;
      end
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // row only moves on a step boundary
  p_row_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> $stable(row_o));
endmodule

// File: rtl/kscan_debounce.sv
module kscan_debounce
  import kscan_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS),
  localparam int NKEYS = ROWS * COLS,
  localparam int KEY_W = $clog2(NKEYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [COLS-1:0]  ret_ni,
  input  logic             lockout_i,
  input  logic             err_mode_i,
  output logic             push_o,
  output logic             sim_o
);
  kstate_e           st_q [NKEYS];
  kstate_e           st_nxt;
  logic [NKEYS-1:0]  busy;
  logic [KEY_W-1:0]  idx;
  logic              closed, other_busy, push_c, sim_c;

  assign idx    = KEY_W'(row_i) * KEY_W'(COLS) + KEY_W'(col_i);
  assign closed = ~ret_ni[col_i];

  always_comb begin
    for (int k = 0; k < NKEYS; k++)
      busy[k] = (st_q[k] == KS_SEEN) || (st_q[k] == KS_HOLD);
  end

  assign other_busy = |(busy & ~(NKEYS'(1) << idx));

  always_comb begin
    st_nxt = st_q[idx];
    push_c = 1'b0;
    sim_c  = 1'b0;
    if (!closed) begin
      st_nxt = KS_OPEN;
    end else begin
      case (st_q[idx])
        KS_OPEN: st_nxt = KS_SEEN;
        KS_SEEN: st_nxt = KS_HOLD;
        KS_HOLD: begin
          // lockout: wait until no other key is debouncing
          if (!(lockout_i && other_busy)) begin
            st_nxt = KS_DONE;
            push_c = 1'b1;
            sim_c  = err_mode_i && other_busy;
          end
        end
        default: st_nxt = KS_DONE;
      endcase
    end
  end

  assign push_o = en_i && tick_i && push_c;
  assign sim_o  = en_i && tick_i && sim_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NKEYS; k++) st_q[k] <= KS_OPEN;
    end else if (!en_i) begin
      for (int k = 0; k < NKEYS; k++) st_q[k] <= KS_OPEN;
    end else if (tick_i) begin
      st_q[idx] <= st_nxt;
    end
  end

  // an accepted key was closed on the previous visit as well
  p_push_debounced_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> (st_q[idx] == KS_HOLD));
endmodule

// File: rtl/kscan_fifo.sv
module kscan_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             sim_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic             rd_i,
  input  logic             clr_i,
  output logic [W-1:0]     rd_data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             underrun_o,
  output logic             overrun_o,
  output logic             sim_err_o,
  output logic             irq_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             und_q, ovr_q, sim_q, irq_q;
  logic             empty, full, blocked, do_wr, do_rd;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign blocked = sim_q || sim_i;
  assign do_wr   = wr_i && !blocked && !full && !clr_i;
  assign do_rd   = rd_i && !empty && !clr_i;
  assign cnt_d   = cnt_q + CNT_W'(do_wr) - CNT_W'(do_rd);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      und_q <= 1'b0;
      ovr_q <= 1'b0;
      sim_q <= 1'b0;
      irq_q <= 1'b0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      und_q <= 1'b0;
      ovr_q <= 1'b0;
      sim_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (do_wr) wp_q <= ptr_inc(wp_q);
      if (do_rd) rp_q <= ptr_inc(rp_q);
      cnt_q <= cnt_d;
      if (rd_i && empty)               und_q <= 1'b1;
      if (wr_i && !blocked && full)    ovr_q <= 1'b1;
      if (wr_i && sim_i)               sim_q <= 1'b1;
      // interrupt drops for one cycle on every read
      irq_q <= (cnt_d != '0) && !rd_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wp_q] <= wr_data_i;
  end

  assign rd_data_o  = mem_q[rp_q];
  assign count_o    = cnt_q;
  assign underrun_o = und_q;
  assign overrun_o  = ovr_q;
  assign sim_err_o  = sim_q;
  assign irq_o      = irq_q;

  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  p_full_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full && !blocked && !clr_i) |=> (ovr_q && cnt_q <= $past(cnt_q)));
  p_irq_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> !irq_o);
  p_irq_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty |-> !irq_o);
  p_sim_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sim_q && !clr_i) |=> (cnt_q <= $past(cnt_q)));
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && !irq_o && !sim_q && !ovr_q));
  p_underrun_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && empty && !clr_i) |=> (und_q && cnt_q == '0));
endmodule

// File: rtl/key_scan_ctrl.sv
module key_scan_ctrl
  import kscan_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  parameter int DEPTH = 8,
  parameter int DIV   = 2,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int COL_W  = $clog2(COLS),
  localparam int DATA_W = 2 + ROW_W + COL_W,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              err_mode_i,
  input  logic [COLS-1:0]   ret_ni,
  input  logic              shift_ni,
  input  logic              ctrl_stb_ni,
  output logic [ROW_W-1:0]  scan_row_o,
  input  logic              rd_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [7:0]        status_o,
  output logic              irq_o
);
  logic              tick, kb_push, kb_sim, stb_q, stb_fall, strobed;
  logic              wr, wr_sim, und, ovr, sim_err, full;
  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col;
  logic [DATA_W-1:0] wr_data;
  logic [CNT_W-1:0]  cnt;

  assign strobed = mode_i[1];

  kscan_timer #(.ROWS(ROWS), .COLS(COLS), .DIV(DIV)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick),
    .row_o  (row),
    .col_o  (col)
  );

  kscan_debounce #(.ROWS(ROWS), .COLS(COLS)) u_debounce (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (!strobed),
    .tick_i     (tick),
    .row_i      (row),
    .col_i      (col),
    .ret_ni     (ret_ni),
    .lockout_i  (mode_i == MODE_LOCKOUT),
    .err_mode_i (err_mode_i && (mode_i == MODE_ROLLOVER)),
    .push_o     (kb_push),
    .sim_o      (kb_sim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_q <= 1'b1;
    else         stb_q <= ctrl_stb_ni;
  end

  assign stb_fall = stb_q && !ctrl_stb_ni;
  assign wr       = strobed ? stb_fall : kb_push;
  assign wr_sim   = !strobed && kb_sim;
  assign wr_data  = strobed ? DATA_W'(ret_ni) : {~ctrl_stb_ni, ~shift_ni, row, col};

  kscan_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr),
    .sim_i      (wr_sim),
    .wr_data_i  (wr_data),
    .rd_i       (rd_i),
    .clr_i      (clr_i),
    .rd_data_o  (rd_data_o),
    .count_o    (cnt),
    .underrun_o (und),
    .overrun_o  (ovr),
    .sim_err_o  (sim_err),
    .irq_o      (irq_o)
  );

  assign full       = (cnt == CNT_W'(DEPTH));
  assign status_o   = {1'b0, sim_err, ovr, und, full, cnt[2:0]};
  assign scan_row_o = row;
endmodule

// File: tb/key_scan_ctrl_tb.sv
module key_scan_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic [1:0] mode_i;
  logic       err_mode_i, shift_ni, ctrl_stb_ni, rd_i, clr_i;
  logic [7:0] ret_ni, rd_data_o, status_o, stb_byte;
  logic [2:0] scan_row_o;
  logic       irq_o, strobed_sel;
  logic [7:0] pressed [8];
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  assign ret_ni = strobed_sel ? stb_byte : ~pressed[scan_row_o];

  key_scan_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .err_mode_i(err_mode_i),
    .ret_ni(ret_ni), .shift_ni(shift_ni), .ctrl_stb_ni(ctrl_stb_ni),
    .scan_row_o(scan_row_o), .rd_i(rd_i), .clr_i(clr_i),
    .rd_data_o(rd_data_o), .status_o(status_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pop();
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic clear();
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
  endtask

  task automatic wait_row(input logic [2:0] r);
    while (scan_row_o != r) @(negedge clk);
  endtask

  task automatic tap(input int r, input int c);
    pressed[r][c] = 1'b1;
    cyc(420);
    pressed[r][c] = 1'b0;
    cyc(140);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 8; r++) pressed[r] = 8'h00;
    rst_ni = 1'b0; mode_i = 2'b00; err_mode_i = 1'b0;
    shift_ni = 1'b1; ctrl_stb_ni = 1'b1; rd_i = 1'b0; clr_i = 1'b0;
    stb_byte = 8'hff; strobed_sel = 1'b0;
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    chk("R11 reset status", status_o, 8'h00);
    chk("R7 reset irq", irq_o, 1'b0);

    // R1 sweep of every key with shift/control patterns
    for (int k = 0; k < 64; k++) begin
      ctrl_stb_ni = ~k[0];
      shift_ni    = ~k[1];
      tap(k / 8, k % 8);
      chk("R1 count", status_o, 8'h01);
      chk("R1 code", rd_data_o, {k[0], k[1], 3'(k / 8), 3'(k % 8)});
      chk("R7 irq pending", irq_o, 1'b1);
      pop();
      chk("R7 irq after last read", irq_o, 1'b0);
    end
    ctrl_stb_ni = 1'b1; shift_ni = 1'b1;

    // R2 debounce timing and early release
    pressed[4][4] = 1'b1;
    cyc(250);
    chk("R2 not before two scans", status_o, 8'h00);
    cyc(200);
    chk("R2 accepted", status_o, 8'h01);
    chk("R2 code", rd_data_o, 8'h24);
    pressed[4][4] = 1'b0;
    cyc(140);
    pop();
    pressed[2][3] = 1'b1;
    cyc(130);
    pressed[2][3] = 1'b0;
    cyc(600);
    chk("R2 early release dropped", status_o, 8'h00);

    // R3 lockout: two keys debouncing together
    wait_row(3'd7);
    pressed[1][2] = 1'b1; pressed[5][6] = 1'b1;
    cyc(700);
    chk("R3 both locked out", status_o, 8'h00);
    pressed[5][6] = 1'b0;
    cyc(500);
    chk("R3 survivor entered", status_o, 8'h01);
    chk("R3 survivor code", rd_data_o, 8'h0a);
    cyc(600);
    chk("R4 held key entered once", status_o, 8'h01);
    pressed[3][3] = 1'b1;
    cyc(450);
    chk("R4 second key while first held", status_o, 8'h02);
    pressed[1][2] = 1'b0; pressed[3][3] = 1'b0;
    cyc(140);
    pop();
    chk("R4 second entry", rd_data_o, 8'h1b);
    pop();

    // R5 rollover: simultaneous keys, scan order
    mode_i = 2'b01;
    wait_row(3'd7);
    pressed[5][6] = 1'b1; pressed[1][2] = 1'b1; pressed[1][7] = 1'b1;
    cyc(600);
    chk("R5 all entered", status_o, 8'h03);
    chk("R5 first", rd_data_o, 8'h0a);
    pop();
    chk("R5 second", rd_data_o, 8'h0f);
    pop();
    chk("R5 third", rd_data_o, 8'h2e);
    pop();
    for (int r = 0; r < 8; r++) pressed[r] = 8'h00;
    cyc(140);

    // R6 overflow with nine keys
    for (int k = 0; k < 9; k++) tap((k * 7) / 8, (k * 7) % 8);
    chk("R6 full status", status_o, 8'h28);
    chk("R7 irq full", irq_o, 1'b1);
    for (int k = 0; k < 8; k++) begin
      chk("R6 order", rd_data_o, 8'(k * 7));
      pop();
    end
    chk("R6 drained", status_o[2:0], 3'd0);
    pop();
    chk("R11 underrun", status_o, 8'h30);
    clear();
    chk("R10 clear status", status_o, 8'h00);

    // R8 special error mode
    err_mode_i = 1'b1;
    tap(6, 1);
    chk("R8 single key normal", status_o, 8'h01);
    wait_row(3'd7);
    pressed[2][2] = 1'b1; pressed[4][5] = 1'b1;
    cyc(600);
    chk("R8 error set no entry", status_o, 8'h41);
    pressed[2][2] = 1'b0; pressed[4][5] = 1'b0;
    cyc(140);
    tap(0, 5);
    chk("R8 writes blocked", status_o, 8'h41);
    chk("R8 irq continues", irq_o, 1'b1);
    chk("R8 old entry readable", rd_data_o, 8'h31);
    pop();
    chk("R8 flag kept after read", status_o, 8'h40);
    clear();
    chk("R10 clear error", status_o, 8'h00);
    err_mode_i = 1'b0;

    // R9 strobed capture, R12 simultaneous read/write
    mode_i = 2'b10; strobed_sel = 1'b1;
    pressed[3][3] = 1'b1;
    stb_byte = 8'ha5;
    cyc(2);
    ctrl_stb_ni = 1'b0;
    cyc(600);
    chk("R9 one entry per edge", status_o, 8'h01);
    chk("R9 raw byte", rd_data_o, 8'ha5);
    ctrl_stb_ni = 1'b1; stb_byte = 8'h3c;
    cyc(1);
    ctrl_stb_ni = 1'b0;
    cyc(1);
    chk("R9 second edge", status_o, 8'h02);
    ctrl_stb_ni = 1'b1; stb_byte = 8'h77;
    cyc(1);
    rd_i = 1'b1; ctrl_stb_ni = 1'b0;
    @(negedge clk);
    rd_i = 1'b0;
    chk("R12 count unchanged", status_o, 8'h02);
    chk("R7 irq low after read", irq_o, 1'b0);
    cyc(1);
    chk("R7 irq back with entries", irq_o, 1'b1);
    chk("R12 head", rd_data_o, 8'h3c);
    pop();
    chk("R12 new entry behind", rd_data_o, 8'h77);
    chk("R10 irq before clear", irq_o, 1'b0);
    cyc(1);
    clear();
    chk("R10 clear empties", status_o, 8'h00);
    chk("R10 irq low", irq_o, 1'b0);
    pressed[3][3] = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule